// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash bus. It decides whether a program or erase running inside the flash has finished. Once started, it issues status reads to one address in pairs and compares the toggle bit of the two reads in each pair. If the bit has stopped changing, the operation is over. If it still changes, the block looks at the timeout bit. A set timeout bit causes one confirmation pair, because the toggle may have stopped at the same moment the timeout bit rose. A toggle that survives the confirmation pair is a failure. On failure the block writes the reset command and then reports the error.

A pass counter sets a limit on how long polling may go on. When the configured number of toggling pairs with a clear timeout bit is reached, the block writes the reset command and raises a separate watchdog pulse. The host may abort polling at any time. After an abort, the next start begins again with a fresh pair of reads and keeps no toggle reference from earlier.

The bus is a single request/acknowledge channel. A request stays asserted with stable fields until the cycle in which the acknowledge is high. Read data is taken in that same cycle.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_req`, `done`, `fail` and `wdog` are all 0, and no bus request is raised while `busy` is 0.
- R2: A `start` pulse while idle begins polling at `poll_addr`. Reads are issued back to back with no request-free cycle while `busy` is 1, and each pair compares bit TOGGLE_POS (default 6) of its first read with the same bit of its second read.
- R3: If the toggle bit is equal in both reads of a pair, `done` pulses for exactly one cycle, in the cycle after the second read's acknowledge. `busy` drops in that cycle and no write is issued.
- R4: If the toggle bit differs and bit TIMEOUT_POS (default 5) of the pair's second read is 0, another pair of reads follows at once.
- R5: If the toggle bit differs and the timeout bit of the second read is 1, exactly one confirmation pair is read. A confirmation pair without a toggle ends in `done`.
- R6: A confirmation pair that still toggles (whatever its timeout bit) causes a single write of RST_CMD (default 0xF0) to the polled address. `fail` then pulses for one cycle after that write is acknowledged.
- R7: The MAX_PAIRS-th pair that toggles with a clear timeout bit does not start another pair. It causes the RST_CMD write instead, followed by a one-cycle `wdog` pulse.
- R8: `abort` during polling reads ends polling once the outstanding read is acknowledged, with no `done`, `fail`, `wdog` or write. `abort` during the reset write is ignored. The next start begins with a fresh first-and-second read pair.
- R9: `start` while `busy` is 1 is ignored: the polled address and the sequence of the run in progress are unchanged.
- R10: While `bus_req` is 1 and `bus_ack` is 0, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values. At most one of `done`, `fail`, `wdog` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| abort | input | 1 | Leave polling early |
| poll_addr | input | ADDR_W | Address used for status reads and the reset write |
| busy | output | 1 | Polling or reset write in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: timeout confirmed, reset written |
| wdog | output | 1 | One-cycle pulse: pass limit reached, reset written |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Bus acknowledge, one per request |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |

## Verification
The hardest case to reach is a toggle that stops in the same pair where the timeout bit rises. A second hard case is the pair that lands exactly on the pass limit. The bench's flash model produces both from two numbers per vector: how many reads the toggle bit keeps flipping, and from which read index the timeout bit is set. The vectors are placed so that a toggle ends one read before, on, or after the limit and the timeout onset. Abort is exercised at two points: during reads, and triggered by the model at the moment it sees the reset write.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RD_FIRST  = 2'd1,
    ST_RD_SECOND = 2'd2,
    ST_RST_WR    = 2'd3
  } tp_state_e;

  typedef enum logic [1:0] {
    V_DONE    = 2'd0,
    V_CONFIRM = 2'd1,
    V_FAIL    = 2'd2,
    V_AGAIN   = 2'd3
  } tp_verdict_e;

  typedef enum logic [1:0] {
    RSN_NONE = 2'd0,
    RSN_FAIL = 2'd1,
    RSN_WDOG = 2'd2
  } tp_reason_e;

  // Outcome of one finished read pair.
  function automatic tp_verdict_e judge_pair(input logic toggled,
                                             input logic timeout,
                                             input logic confirming);
    if (!toggled)        return V_DONE;
    else if (confirming) return V_FAIL;
    else if (timeout)    return V_CONFIRM;
    else                 return V_AGAIN;
  endfunction

  // Did a selected status bit change between two reads.
  function automatic logic bit_changed(input logic first_bit,
                                       input logic second_bit);
    return first_bit ^ second_bit;
  endfunction

endpackage

// File: rtl/tp_bus_master.sv
module tp_bus_master #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_we,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_wdata,
  output logic              op_done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack
);

  logic              req_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign op_done = req_q & bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (issue) begin
      req_q   <= 1'b1;
      we_q    <= issue_we;
      addr_q  <= issue_addr;
      wdata_q <= issue_wdata;
    end else if (op_done) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
    end
  end

  assign bus_req   = req_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

endmodule

// File: rtl/tp_pair_eval.sv
module tp_pair_eval #(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_POS  = 6,
  parameter int TIMEOUT_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_first,
  input  logic [DATA_W-1:0] rd_data,
  output logic              toggled,
  output logic              timeout
);
  import tp_pkg::*;

  logic first_bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             first_bit_q <= 1'b0;
    else if (capture_first) first_bit_q <= rd_data[TOGGLE_POS];
  end

  assign toggled = bit_changed(first_bit_q, rd_data[TOGGLE_POS]);
  assign timeout = rd_data[TIMEOUT_POS];

endmodule

// File: rtl/tp_pass_counter.sv
module tp_pass_counter #(
  parameter int MAX_PAIRS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic limit_next
);
  localparam int CNT_W = $clog2(MAX_PAIRS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (bump)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign limit_next = (cnt_q == CNT_W'(MAX_PAIRS - 1));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int              ADDR_W      = 22,
  parameter int              DATA_W      = 8,
  parameter int              TOGGLE_POS  = 6,
  parameter int              TIMEOUT_POS = 5,
  parameter int              MAX_PAIRS   = 4096,
  parameter logic [DATA_W-1:0] RST_CMD   = 'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] poll_addr,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              wdog,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  import tp_pkg::*;

  tp_state_e   state_q, state_d;
  tp_reason_e  reason_q, reason_d;
  tp_verdict_e verdict;
  logic [ADDR_W-1:0] addr_q;
  logic confirm_q, confirm_d;
  logic abort_q, abort_d;
  logic done_q, done_d, fail_q, fail_d, wdog_q, wdog_d;

  // Named internal events (also observed by the checker).
  logic issue, issue_we, capture_first, cnt_clear, cnt_bump;
  logic op_done, pair_eval_en, pair_toggled, pair_timeout, limit_next;
  logic abort_hit, in_reads;
  logic [ADDR_W-1:0] issue_addr;

  assign in_reads     = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND);
  assign abort_hit    = in_reads & (abort | abort_q);
  assign pair_eval_en = (state_q == ST_RD_SECOND) & op_done;
  assign issue_addr   = (state_q == ST_IDLE) ? poll_addr : addr_q;
  assign verdict      = judge_pair(pair_toggled, pair_timeout, confirm_q);

  tp_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_we   (issue_we),
    .issue_addr (issue_addr),
    .issue_wdata(RST_CMD),
    .op_done    (op_done),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack)
  );

  tp_pair_eval #(.DATA_W(DATA_W), .TOGGLE_POS(TOGGLE_POS),
                 .TIMEOUT_POS(TIMEOUT_POS)) u_eval (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_first(capture_first),
    .rd_data      (bus_rdata),
    .toggled      (pair_toggled),
    .timeout      (pair_timeout)
  );

  tp_pass_counter #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cnt_clear),
    .bump      (cnt_bump),
    .limit_next(limit_next)
  );

  always_comb begin
    state_d       = state_q;
    reason_d      = reason_q;
    confirm_d     = confirm_q;
    abort_d       = abort_q | (in_reads & abort);
    issue         = 1'b0;
    issue_we      = 1'b0;
    capture_first = 1'b0;
    cnt_clear     = 1'b0;
    cnt_bump      = 1'b0;
    done_d        = 1'b0;
    fail_d        = 1'b0;
    wdog_d        = 1'b0;
    case (state_q)
      ST_IDLE: begin
        abort_d = 1'b0;
        if (start) begin
          issue     = 1'b1;
          cnt_clear = 1'b1;
          confirm_d = 1'b0;
          reason_d  = RSN_NONE;
          state_d   = ST_RD_FIRST;
        end
      end
      ST_RD_FIRST: begin
        if (op_done) begin
          if (abort_hit) begin
            abort_d = 1'b0;
            state_d = ST_IDLE;
          end else begin
            capture_first = 1'b1;
            issue         = 1'b1;
            state_d       = ST_RD_SECOND;
          end
        end
      end
      ST_RD_SECOND: begin
        if (op_done) begin
          if (abort_hit) begin
            abort_d = 1'b0;
            state_d = ST_IDLE;
          end else begin
            case (verdict)
              V_DONE: begin
                done_d  = 1'b1;
                state_d = ST_IDLE;
              end
              V_FAIL: begin
                issue    = 1'b1;
                issue_we = 1'b1;
                reason_d = RSN_FAIL;
                state_d  = ST_RST_WR;
              end
              V_CONFIRM: begin
                confirm_d = 1'b1;
                issue     = 1'b1;
                state_d   = ST_RD_FIRST;
              end
              default: begin
                if (limit_next) begin
                  issue    = 1'b1;
                  issue_we = 1'b1;
                  reason_d = RSN_WDOG;
                  state_d  = ST_RST_WR;
                end else begin
                  cnt_bump = 1'b1;
                  issue    = 1'b1;
                  state_d  = ST_RD_FIRST;
                end
              end
            endcase
          end
        end
      end
      default: begin
        abort_d = 1'b0;
        if (op_done) begin
          fail_d  = (reason_q == RSN_FAIL);
          wdog_d  = (reason_q == RSN_WDOG);
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      reason_q  <= RSN_NONE;
      confirm_q <= 1'b0;
      abort_q   <= 1'b0;
      addr_q    <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
      wdog_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      reason_q  <= reason_d;
      confirm_q <= confirm_d;
      abort_q   <= abort_d;
      done_q    <= done_d;
      fail_q    <= fail_d;
      wdog_q    <= wdog_d;
      if (state_q == ST_IDLE && start) addr_q <= poll_addr;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign fail = fail_q;
  assign wdog = wdog_q;

endmodule

// File: rtl/toggle_poll_ctrl_chk.sv
module toggle_poll_ctrl_chk #(
  parameter int                ADDR_W  = 22,
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_CMD = 'hF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              wdog,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pair_eval_en,
  input logic              pair_toggled,
  input logic              pair_timeout,
  input logic              confirm_q,
  input logic              limit_next,
  input logic              abort_hit
);

  p_idle_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr)
                            && $stable(bus_wdata));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, wdog}));

  p_still_pair_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_eval_en && !pair_toggled && !abort_hit |=> done && !busy);

  p_done_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_ack && !bus_we));

  p_again_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_eval_en && pair_toggled && !pair_timeout && !confirm_q && !limit_next
    && !abort_hit |=> bus_req && !bus_we);

  p_confirm_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_eval_en && pair_toggled && pair_timeout && !confirm_q && !abort_hit
    |=> bus_req && !bus_we && confirm_q);

  p_fail_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_eval_en && pair_toggled && confirm_q && !abort_hit |=> bus_req && bus_we);

  p_cmd_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> bus_wdata == RST_CMD);

  p_fail_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(bus_ack && bus_we));

  p_limit_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_eval_en && pair_toggled && !pair_timeout && !confirm_q && limit_next
    && !abort_hit |=> bus_req && bus_we);

  p_wdog_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdog |-> $past(bus_ack && bus_we));

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_eval_en && abort_hit |=> !busy && !done && !bus_req);

endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CMD(RST_CMD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .fail        (fail),
  .wdog        (wdog),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_ack     (bus_ack),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .pair_eval_en(pair_eval_en),
  .pair_toggled(pair_toggled),
  .pair_timeout(pair_timeout),
  .confirm_q   (confirm_q),
  .limit_next  (limit_next),
  .abort_hit   (abort_hit)
);

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb;

  localparam int ADDR_W = 22;
  localparam int DATA_W = 8;
  localparam int LIMIT  = 8;
  localparam int NVEC   = 8;
  // fields: toggle flips, timeout onset read, outcome (0 done 1 fail 2 wdog), reads, requirement
  localparam int VEC [NVEC][5] = '{
    '{  0, 999, 0,  2, 3},
    '{  3, 999, 0,  6, 4},
    '{  4, 999, 0,  6, 4},
    '{  1,   1, 0,  4, 5},
    '{  3,   3, 0,  6, 5},
    '{ 50,   3, 1,  6, 6},
    '{ 13, 999, 0, 16, 7},
    '{100, 999, 2, 16, 7}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic [ADDR_W-1:0] poll_addr = '0;
  logic busy, done, fail, wdog, bus_req, bus_we, bus_ack = 1'b0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata = '0;

  int checks = 0, fails = 0, cyc = 0;
  int m_flips = 0, m_to = 999, m_k = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  int n_rd = 0, n_wr = 0, n_done = 0, n_fail = 0, n_wdog = 0, n_gap = 0, n_badaddr = 0;
  logic [DATA_W-1:0] last_wdata = '0;
  int r_rd, r_wr, r_done, r_fail, r_wdog, r_gap, r_bad;

  always #5 clk = ~clk;

  toggle_poll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PAIRS(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .poll_addr(poll_addr),
    .busy(busy), .done(done), .fail(fail), .wdog(wdog),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  function automatic string rq(input int id);
    case (id)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      9: return "R9"; default: return "R10";
    endcase
  endfunction

  // Flash status model: toggle bit 6 flips on each read up to m_flips, timeout bit 5 from m_to.
  function automatic logic [DATA_W-1:0] status_at(input int k);
    logic [DATA_W-1:0] d;
    int t;
    d = DATA_W'(k * 37 + 11);
    t = (k < m_flips) ? k : m_flips;
    d[6] = t[0];
    d[5] = (k >= m_to);
    return d;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bus slave and monitors, all sampled on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (done) n_done++;
      if (fail) n_fail++;
      if (wdog) n_wdog++;
      if (busy && !bus_req) n_gap++;
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        bus_ack = 1'b1;
        if (bus_addr != m_addr) n_badaddr++;
        if (bus_we) begin
          n_wr++;
          last_wdata = bus_wdata;
        end else begin
          bus_rdata = status_at(m_k);
          m_k++;
          n_rd++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  // mode: 0 none, 1 extra start after delay, 2 abort after delay, 3 abort at reset write
  task automatic run_poll(input int flips, input int to_at, input logic [ADDR_W-1:0] a,
                          input int mode, input int dly);
    int s_rd, s_wr, s_done, s_fail, s_wdog, s_gap, s_bad;
    @(negedge clk);
    m_flips = flips; m_to = to_at; m_k = 0; m_addr = a;
    s_rd = n_rd; s_wr = n_wr; s_done = n_done; s_fail = n_fail;
    s_wdog = n_wdog; s_gap = n_gap; s_bad = n_badaddr;
    poll_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      begin
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      end
      begin
        if (mode == 1 || mode == 2) begin
          repeat (dly) @(negedge clk);
          poll_addr = a ^ 22'h15A5A;
          if (mode == 1) start = 1'b1; else abort = 1'b1;
          @(negedge clk);
          start = 1'b0; abort = 1'b0;
        end else if (mode == 3) begin
          for (int i = 0; i < 2000 && !(bus_req && bus_we); i++) @(negedge clk);
          abort = 1'b1;
          @(negedge clk);
          abort = 1'b0;
        end
      end
    join
    repeat (3) @(negedge clk);
    r_rd = n_rd - s_rd; r_wr = n_wr - s_wr; r_done = n_done - s_done;
    r_fail = n_fail - s_fail; r_wdog = n_wdog - s_wdog;
    r_gap = n_gap - s_gap; r_bad = n_badaddr - s_bad;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 outcomes", int'(done) + int'(fail) + int'(wdog), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", int'(busy) + int'(bus_req), 0);

    for (int v = 0; v < NVEC; v++) begin
      run_poll(VEC[v][0], VEC[v][1], ADDR_W'(22'h1000 + v * 3), 0, 0);
      chk({rq(VEC[v][4]), " done pulses"}, r_done, (VEC[v][2] == 0) ? 1 : 0);
      chk({rq(VEC[v][4]), " fail pulses"}, r_fail, (VEC[v][2] == 1) ? 1 : 0);
      chk({rq(VEC[v][4]), " wdog pulses"}, r_wdog, (VEC[v][2] == 2) ? 1 : 0);
      chk("R2 read count", r_rd, VEC[v][3]);
      chk("R6 write count", r_wr, (VEC[v][2] == 0) ? 0 : 1);
      if (VEC[v][2] != 0) chk("R6 reset command value", int'(last_wdata), 'hF0);
      chk("R2 back-to-back reads", r_gap, 0);
      chk("R10 address held", r_bad, 0);
    end

    // R9: second start during a run changes nothing
    run_poll(7, 999, 22'h2A0F0, 1, 4);
    chk("R9 done", r_done, 1);
    chk("R9 read count", r_rd, 10);
    chk("R9 address", r_bad, 0);

    // R8: abort during reads
    run_poll(100, 999, 22'h00333, 2, 5);
    chk("R8 no outcome", r_done + r_fail + r_wdog, 0);
    chk("R8 no write", r_wr, 0);
    chk("R8 left early", int'(r_rd < 10), 1);
    chk("R8 idle", int'(busy), 0);
    // R8: fresh double read after abort (toggle stops with timeout: 4 reads)
    run_poll(1, 1, 22'h00334, 0, 0);
    chk("R8 fresh start done", r_done, 1);
    chk("R8 fresh start reads", r_rd, 4);

    // R8: abort during reset write is ignored
    run_poll(50, 3, 22'h3FFFF, 3, 0);
    chk("R8 abort at write fail", r_fail, 1);
    chk("R8 abort at write writes", r_wr, 1);

    // R7 boundary: limit reached with timeout onset later than the limit
    run_poll(15, 999, 22'h00010, 0, 0);
    chk("R7 wdog at exact limit", r_wdog, 1);
    chk("R7 reads at limit", r_rd, 16);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule